// File: doc/BRIEF.md
# Multi-Mode Display Host Port

This block is the host-facing front end of a display controller. A microcontroller reaches it over one shared set of pins. Two select inputs decide how those pins are read. The pins can act as a 6800-style parallel bus with an enable clock and a read/write line. They can act as an 8080-style parallel bus with separate active-low write and read strobes. They can also act as a write-only serial link, where bit 0 of the bus carries the data and the shared strobe pin is the serial clock.

Every host input is brought into the system clock domain through a two-flop synchroniser. Strobe edges are then found by comparing each synchronised level with its value one cycle earlier. Each byte that arrives is handed to the controller core on an internal port, with a data/command flag and a strobe that is valid for one cycle.

On a parallel read, the block drives the bus with one of two bytes. It returns the display byte supplied by the core when the data/command line is high. It returns a status byte carrying the busy flag when that line is low. A read acknowledge pulse tells the core that the host has finished a read cycle. An asynchronous active-low reset, released synchronously, brings the whole block back to its power-on state.

Top module: `disp_host_if`

## Requirements
- R1: While reset is asserted, and after it is released, `wr_valid`, `rd_ack` and `host_bus_oe` are 0. Reset also discards a partly received serial byte.
- R2: With `sel_par`=1 and `sel_m68`=1, a falling edge of `host_stb` while `host_rw`=0 and `host_cs_n`=0 delivers `host_bus_in` on `wr_data` and `host_dc` on `wr_dc`.
- R3: With `sel_par`=1 and `sel_m68`=0, a rising edge of `host_stb` (the write strobe) while `host_cs_n`=0 delivers the bus byte and the `host_dc` level.
- R4: With `sel_par`=0, each falling edge of `host_stb` shifts in `host_bus_in[0]`. The first bit is the most significant one. The eighth bit completes the byte, and `host_dc` is taken at that bit. `host_bus_in[7:1]` and `host_rw` have no effect.
- R5: While `host_cs_n`=1, strobe edges produce no byte and no read acknowledge. A rise of `host_cs_n` discards a partly received serial byte.
- R6: Each accepted byte raises `wr_valid` for exactly one clock cycle.
- R7: During a parallel read, `host_bus_out` equals `rd_data` when `host_dc`=1. When `host_dc`=0 it equals the status byte: `busy` in bit 7 and zeros in bits 6..0.
- R8: `host_bus_oe` is 1 only when a parallel mode is selected and `host_cs_n`=0. In 6800 mode this also needs `host_rw`=1; in 8080 mode it needs `host_rw` (the read strobe) low. It is never 1 in serial mode.
- R9: `rd_ack` pulses for one cycle at the end of a read. In 6800 mode that is a falling `host_stb` with `host_rw`=1. In 8080 mode it is a rising `host_rw`. A read cycle never raises `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_par | input | 1 | 1 = parallel bus, 0 = serial |
| sel_m68 | input | 1 | 1 = 6800-style, 0 = 8080-style |
| host_dc | input | 1 | 1 = display data, 0 = command/status |
| host_cs_n | input | 1 | Active-low chip enable |
| host_stb | input | 1 | 6800 enable clock, 8080 write strobe, or serial clock |
| host_rw | input | 1 | 6800 read/write select or 8080 active-low read strobe |
| host_bus_in | input | 8 | Host bus input; bit 0 is serial data |
| host_bus_out | output | 8 | Read data driven toward the host |
| host_bus_oe | output | 1 | Bus output enable |
| rd_data | input | 8 | Display byte from the core for reads |
| busy | input | 1 | Busy flag reported in the status byte |
| wr_valid | output | 1 | One-cycle strobe for an accepted byte |
| wr_dc | output | 1 | Data/command flag of the accepted byte |
| wr_data | output | 8 | Accepted byte |
| rd_ack | output | 1 | One-cycle read-complete pulse |

## Verification
The hardest state to reach from the ports is a serial byte cut off in the middle. The bench must bring it about twice. The first case is a chip enable rise partway through a byte. The second is a reset during shifting. After each, the next complete byte must arrive clean and not shifted by the stale bits. The stimulus reaches both with directed partial transfers followed by a full byte. Random serial bytes fill the unused bus bits and the read line with noise, which shows they have no effect.

// File: rtl/dhi_pkg.sv
package dhi_pkg;
  typedef enum logic [1:0] {
    MODE_SER = 2'd0,
    MODE_M68 = 2'd1,
    MODE_I80 = 2'd2
  } bus_mode_e;

  function automatic bus_mode_e decode_mode(input logic par, input logic m68);
    if (!par)    return MODE_SER;
    else if (m68) return MODE_M68;
    else         return MODE_I80;
  endfunction
endpackage

// File: rtl/dhi_sync.sv
module dhi_sync #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dhi_edge.sv
module dhi_edge #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~prev_q[i];
    assign fall[i] = ~lvl[i] & prev_q[i];
  end
endmodule

// File: rtl/dhi_ser_rx.sv
module dhi_ser_rx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            sck_fall,
  input  logic            sdi,
  output logic            done,
  output logic [BITS-1:0] byte_out
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [BITS-1:0] shift_q, shift_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            take;

  assign take = enable & sck_fall;

  always_comb begin
    shift_d  = shift_q;
    cnt_d    = cnt_q;
    done     = 1'b0;
    byte_out = {shift_q[BITS-2:0], sdi};
    if (!enable) begin
      cnt_d = '0;
    end else if (take) begin
      shift_d = {shift_q[BITS-2:0], sdi};
      if (cnt_q == LAST) begin
        done  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (take) shift_q <= shift_d;
    end
  end
endmodule

// File: rtl/dhi_rd_mux.sv
module dhi_rd_mux #(
  parameter int DW       = 8,
  parameter int BUSY_BIT = DW - 1
) (
  input  dhi_pkg::bus_mode_e mode,
  input  logic               cs_n,
  input  logic               rw,
  input  logic               dc,
  input  logic [DW-1:0]      rd_data,
  input  logic               busy,
  output logic [DW-1:0]      bus_out,
  output logic               bus_oe
);
  import dhi_pkg::*;
  logic [DW-1:0] status;

  always_comb begin
    status           = '0;
    status[BUSY_BIT] = busy;
    bus_out          = dc ? rd_data : status;
    unique case (mode)
      MODE_M68: bus_oe = ~cs_n & rw;
      MODE_I80: bus_oe = ~cs_n & ~rw;
      default:  bus_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/disp_host_if.sv
module disp_host_if #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_par,
  input  logic          sel_m68,
  input  logic          host_dc,
  input  logic          host_cs_n,
  input  logic          host_stb,
  input  logic          host_rw,
  input  logic [DW-1:0] host_bus_in,
  output logic [DW-1:0] host_bus_out,
  output logic          host_bus_oe,
  input  logic [DW-1:0] rd_data,
  input  logic          busy,
  output logic          wr_valid,
  output logic          wr_dc,
  output logic [DW-1:0] wr_data,
  output logic          rd_ack
);
  import dhi_pkg::*;

  localparam int SW = DW + 6;
  localparam logic [SW-1:0] SYNC_RST = {3'b000, 3'b111, {DW{1'b0}}};

  // reset: asserted asynchronously, released on clk
  logic rst_meta_q, rst_sys_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sys_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sys_n  <= rst_meta_q;
    end
  end

  logic [SW-1:0] raw, syn;
  assign raw = {sel_par, sel_m68, host_dc, host_cs_n, host_stb, host_rw, host_bus_in};

  dhi_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_sys_n), .d(raw), .q(syn)
  );

  logic          par_s, m68_s, dc_s, cs_n_s, stb_s, rw_s;
  logic [DW-1:0] bus_s;
  assign {par_s, m68_s, dc_s, cs_n_s, stb_s, rw_s, bus_s} = syn;

  bus_mode_e mode;
  assign mode = decode_mode(par_s, m68_s);

  logic [1:0] rise, fall;
  dhi_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
    .clk(clk), .rst_n(rst_sys_n), .lvl({stb_s, rw_s}), .rise(rise), .fall(fall)
  );

  logic stb_rise, stb_fall, rw_rise;
  assign stb_rise = rise[1];
  assign stb_fall = fall[1];
  assign rw_rise  = rise[0];

  logic          ser_done;
  logic [DW-1:0] ser_byte;
  dhi_ser_rx #(.BITS(DW)) u_ser (
    .clk(clk), .rst_n(rst_sys_n),
    .enable((mode == MODE_SER) & ~cs_n_s),
    .sck_fall(stb_fall), .sdi(bus_s[0]),
    .done(ser_done), .byte_out(ser_byte)
  );

  dhi_rd_mux #(.DW(DW)) u_rd (
    .mode(mode), .cs_n(cs_n_s), .rw(rw_s), .dc(dc_s),
    .rd_data(rd_data), .busy(busy),
    .bus_out(host_bus_out), .bus_oe(host_bus_oe)
  );

  // next-state for the core-side port
  logic          wv_d, ack_d, dc_d;
  logic [DW-1:0] data_d;
  always_comb begin
    wv_d   = 1'b0;
    ack_d  = 1'b0;
    dc_d   = wr_dc;
    data_d = wr_data;
    if (!cs_n_s) begin
      unique case (mode)
        MODE_M68: begin
          if (stb_fall && !rw_s) begin
            wv_d = 1'b1; dc_d = dc_s; data_d = bus_s;
          end
          if (stb_fall && rw_s) ack_d = 1'b1;
        end
        MODE_I80: begin
          if (stb_rise) begin
            wv_d = 1'b1; dc_d = dc_s; data_d = bus_s;
          end
          if (rw_rise) ack_d = 1'b1;
        end
        default: begin
          if (ser_done) begin
            wv_d = 1'b1; dc_d = dc_s; data_d = ser_byte;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      wr_valid <= 1'b0;
      rd_ack   <= 1'b0;
      wr_dc    <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_valid <= wv_d;
      rd_ack   <= ack_d;
      if (wv_d) begin
        wr_dc   <= dc_d;
        wr_data <= data_d;
      end
    end
  end
endmodule

// File: rtl/disp_host_if_chk.sv
module disp_host_if_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          par_s,
  input logic          cs_n_s,
  input logic          dc_s,
  input logic          wr_valid,
  input logic          rd_ack,
  input logic          host_bus_oe,
  input logic [DW-1:0] host_bus_out
);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  p_no_wr_on_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> !wr_valid);

  p_cs_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(!cs_n_s));

  p_no_oe_serial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !par_s |-> !host_bus_oe);

  p_oe_needs_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !host_bus_oe);

  p_status_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_bus_oe && !dc_s) |-> (host_bus_out[DW-2:0] == '0));
endmodule

bind disp_host_if disp_host_if_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sys_n), .par_s(par_s), .cs_n_s(cs_n_s), .dc_s(dc_s),
  .wr_valid(wr_valid), .rd_ack(rd_ack),
  .host_bus_oe(host_bus_oe), .host_bus_out(host_bus_out)
);

// File: tb/tb_disp_host_if.sv
`timescale 1ns/1ps
module tb_disp_host_if;
  localparam int STEP = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, sel_par, sel_m68, host_dc, host_cs_n, host_stb, host_rw, busy;
  logic [7:0] host_bus_in, rd_data, host_bus_out, wr_data;
  logic       host_bus_oe, wr_valid, wr_dc, rd_ack;

  disp_host_if dut (
    .clk(clk), .rst_n(rst_n), .sel_par(sel_par), .sel_m68(sel_m68),
    .host_dc(host_dc), .host_cs_n(host_cs_n), .host_stb(host_stb), .host_rw(host_rw),
    .host_bus_in(host_bus_in), .host_bus_out(host_bus_out), .host_bus_oe(host_bus_oe),
    .rd_data(rd_data), .busy(busy), .wr_valid(wr_valid), .wr_dc(wr_dc),
    .wr_data(wr_data), .rd_ack(rd_ack)
  );

  int checks = 0, errors = 0, got = 0, acks = 0;
  logic [8:0] exp_q[$];
  logic       prev_valid = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic dc, input logic [7:0] d, input logic b);
    return dc ? d : {b, 7'b0};
  endfunction

  // monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      got++;
      chk(!prev_valid, "R6 pulse width", 1, 0);
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", {wr_dc, wr_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({wr_dc, wr_data} == e, "R2/R3/R4 byte", {wr_dc, wr_data}, e);
      end
    end
    if (rst_n && rd_ack) begin
      acks++;
      chk(!wr_valid, "R9 read gave write", 1, 0);
    end
    prev_valid = rst_n & wr_valid;
  end

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_mode(input logic par, input logic m68);
    host_cs_n = 1'b1;
    waitc(STEP);
    sel_par = par; sel_m68 = m68;
    host_stb = (par && m68) ? 1'b0 : 1'b1;
    host_rw  = 1'b1;
    waitc(STEP);
  endtask

  task automatic m68_write(input logic dc, input logic [7:0] b);
    host_rw = 1'b0; host_dc = dc; host_bus_in = b; host_cs_n = 1'b0;
    waitc(STEP); host_stb = 1'b1; waitc(STEP); host_stb = 1'b0; waitc(STEP);
    host_cs_n = 1'b1; host_rw = 1'b1; waitc(STEP);
  endtask

  task automatic i80_write(input logic dc, input logic [7:0] b);
    host_dc = dc; host_bus_in = b; host_cs_n = 1'b0;
    waitc(STEP); host_stb = 1'b0; waitc(STEP); host_stb = 1'b1; waitc(STEP);
    host_cs_n = 1'b1; waitc(STEP);
  endtask

  task automatic ser_bits(input logic [7:0] b, input int n, input logic dc);
    for (int i = 7; i > 7 - n; i--) begin
      host_bus_in = {7'($urandom), b[i]};
      host_rw = 1'($urandom);
      if (i == 0) host_dc = dc; else host_dc = 1'($urandom);
      waitc(STEP); host_stb = 1'b0; waitc(STEP); host_stb = 1'b1;
    end
  endtask

  task automatic ser_write(input logic dc, input logic [7:0] b);
    host_cs_n = 1'b0; waitc(STEP);
    ser_bits(b, 8, dc);
    waitc(STEP);
    chk(!host_bus_oe, "R8 oe in serial", host_bus_oe, 0);
    host_cs_n = 1'b1; waitc(STEP);
  endtask

  task automatic do_read(input logic m68, input logic dc, input logic [7:0] d, input logic b);
    int a0;
    logic [7:0] e;
    a0 = acks;
    e = exp_rd(dc, d, b);
    host_dc = dc; rd_data = d; busy = b; host_cs_n = 1'b0;
    if (m68) begin
      host_rw = 1'b1; waitc(STEP); host_stb = 1'b1; waitc(STEP);
    end else begin
      waitc(STEP); host_rw = 1'b0; waitc(STEP);
    end
    @(negedge clk);
    chk(host_bus_oe, "R8 oe in read", host_bus_oe, 1);
    chk(host_bus_out == e, "R7 read byte", host_bus_out, e);
    if (m68) host_stb = 1'b0; else host_rw = 1'b1;
    waitc(STEP);
    chk(acks == a0 + 1, "R9 read ack", acks - a0, 1);
    host_cs_n = 1'b1; waitc(STEP);
    @(negedge clk);
    chk(!host_bus_oe, "R8 oe after cs high", host_bus_oe, 0);
  endtask

  task automatic finish_run();
    waitc(4 * STEP);
    chk(exp_q.size() == 0, "R2/R3/R4 missing bytes", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    waitc(150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic       d;
    int         g0;
    void'($urandom(32'd1809));
    rst_n = 1'b0; sel_par = 1'b1; sel_m68 = 1'b1; host_dc = 1'b0; host_cs_n = 1'b1;
    host_stb = 1'b0; host_rw = 1'b1; host_bus_in = 8'h00; rd_data = 8'h00; busy = 1'b0;
    waitc(5);
    @(negedge clk);
    chk(!wr_valid && !rd_ack && !host_bus_oe, "R1 outputs in reset",
        {wr_valid, rd_ack, host_bus_oe}, 0);
    rst_n = 1'b1;
    waitc(STEP);
    @(negedge clk);
    chk(!wr_valid && !rd_ack && !host_bus_oe, "R1 outputs after reset",
        {wr_valid, rd_ack, host_bus_oe}, 0);

    // R2: 6800 writes
    set_mode(1'b1, 1'b1);
    exp_q.push_back({1'b0, 8'hA5}); m68_write(1'b0, 8'hA5);
    exp_q.push_back({1'b1, 8'h3C}); m68_write(1'b1, 8'h3C);
    // R5: strobe while chip enable high
    g0 = got;
    host_rw = 1'b0; host_bus_in = 8'hFF;
    waitc(STEP); host_stb = 1'b1; waitc(STEP); host_stb = 1'b0; waitc(3 * STEP);
    host_rw = 1'b1;
    chk(got == g0, "R5 cs high ignored", got - g0, 0);
    // R7 R8 R9: 6800 reads
    do_read(1'b1, 1'b1, 8'h5A, 1'b1);
    do_read(1'b1, 1'b0, 8'h5A, 1'b1);
    do_read(1'b1, 1'b0, 8'h77, 1'b0);

    // R3: 8080 writes and reads
    set_mode(1'b1, 1'b0);
    exp_q.push_back({1'b1, 8'h00}); i80_write(1'b1, 8'h00);
    exp_q.push_back({1'b0, 8'hFF}); i80_write(1'b0, 8'hFF);
    do_read(1'b0, 1'b1, 8'hC3, 1'b0);
    do_read(1'b0, 1'b0, 8'hC3, 1'b1);

    // R4: serial writes
    set_mode(1'b0, 1'b0);
    exp_q.push_back({1'b1, 8'h81}); ser_write(1'b1, 8'h81);
    exp_q.push_back({1'b0, 8'h6E}); ser_write(1'b0, 8'h6E);
    // R5: partial serial byte cut by chip enable
    g0 = got;
    host_cs_n = 1'b0; waitc(STEP);
    ser_bits(8'hFF, 3, 1'b0);
    host_cs_n = 1'b1; waitc(3 * STEP);
    chk(got == g0, "R5 partial byte dropped", got - g0, 0);
    exp_q.push_back({1'b0, 8'h12}); ser_write(1'b0, 8'h12);
    // R1: reset during shifting
    host_cs_n = 1'b0; waitc(STEP);
    ser_bits(8'hF0, 4, 1'b0);
    rst_n = 1'b0; waitc(3); rst_n = 1'b1;
    host_cs_n = 1'b1; waitc(2 * STEP);
    exp_q.push_back({1'b1, 8'h2B}); ser_write(1'b1, 8'h2B);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int m;
      m = $urandom_range(0, 2);
      b = 8'($urandom); d = 1'($urandom);
      if (m == 0) begin set_mode(1'b0, 1'($urandom)); exp_q.push_back({d, b}); ser_write(d, b); end
      else if (m == 1) begin
        set_mode(1'b1, 1'b1);
        if ($urandom_range(0, 1) == 1) begin exp_q.push_back({d, b}); m68_write(d, b); end
        else do_read(1'b1, d, b, 1'($urandom));
      end else begin
        set_mode(1'b1, 1'b0);
        if ($urandom_range(0, 1) == 1) begin exp_q.push_back({d, b}); i80_write(d, b); end
        else do_read(1'b0, d, b, 1'($urandom));
      end
    end
    finish_run();
  end
endmodule